// File: doc/BRIEF.md
# Row-Miss Tracking Migration Filter

This block sits in a hybrid-memory controller, in front of a large, slow memory whose banks each hold one open row. For every access to that memory it records which row each bank has open and reports whether the access hits the open row. A small set-associative table keeps a miss counter for each recently touched row. A row that keeps missing the row buffer within one interval is a good candidate for copying into the fast memory. When its count reaches a programmable threshold, the block issues a migration request that names the row.

Rows that mostly hit the open row never build up a count, so they stay in slow memory. The whole table is cleared at a programmable cycle interval, so only rows that miss repeatedly within one interval are promoted. Accesses to rows already held in the fast memory are accepted but ignored. While a migration request waits for its consumer, the block stalls the access stream.

Top module: `rowmiss_promoter`

## Requirements
- R1: An accepted access with `acc_fast` high changes neither the open-row state nor any count, and never raises a request.
- R2: The row is `acc_addr >> ROW_SHIFT`, and its low `log2(BANKS)` bits select the bank. An access hits (`acc_rb_hit` = 1) when the bank has an open row equal to that row. Otherwise it misses, and the accessed row becomes the bank's open row. No bank has an open row after reset.
- R3: Only row-buffer misses increment a row's count. Row-buffer hits leave the count unchanged.
- R4: The low `log2(SETS)` row bits pick the table set, and the remaining bits form the tag. On a table miss, the lowest-numbered invalid way is allocated, or else the least recently used way. The new count is 1 for a row-buffer miss and 0 for a hit. Every allocation or update makes that way the most recently used.
- R5: After an accepted row-buffer miss whose updated count is at least `cfg_threshold`, `mig_valid` rises on the next cycle with `mig_row` set to that row. A threshold of 0 disables requests, and a row-buffer hit never raises one.
- R6: A row that has just been requested leaves the table, so its next miss starts again from a count of 1.
- R7: `mig_valid` and `mig_row` hold until `mig_ready` is high. `acc_ready` is low exactly while `mig_valid` is high and `mig_ready` is low.
- R8: When `cfg_interval` is nonzero, the table is emptied every `cfg_interval` cycles, counted from reset. An access accepted in a clearing cycle counts as the first event of the new interval. Open rows survive the clear. An interval of 0 never clears.
- R9: Counts saturate at their maximum value and do not wrap.
- R10: After reset, `mig_valid` is low and `acc_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | Access present |
| acc_ready | output | 1 | Access accepted this cycle when high |
| acc_fast | input | 1 | Accessed row already lives in fast memory |
| acc_addr | input | ADDR_W | Access byte address |
| acc_rb_hit | output | 1 | Access hits the open row of its bank |
| mig_valid | output | 1 | Migration request pending |
| mig_ready | input | 1 | Consumer takes the request |
| mig_row | output | ADDR_W-ROW_SHIFT | Row to migrate |
| cfg_threshold | input | CNT_W | Miss count that triggers migration; 0 disables |
| cfg_interval | input | IVL_W | Clearing period in cycles; 0 disables |

## Verification
The periodic table clear and a counter update can fall on the same cycle. When they do, the access must be counted into the freshly emptied table and not added to its old count. The bench provokes this directly. It first gives a row a count of 1, then waits until its own interval counter says the next edge clears the table, and sends a second miss to that row. With a threshold of 2, no request may follow. A long mixed stream with short intervals then makes the two coincide many more times, and each result is compared against a cycle-by-cycle model of the requirements.

// File: rtl/rowmiss_promoter.sv
module rowmiss_promoter #(
  parameter int ADDR_W    = 40,
  parameter int ROW_SHIFT = 12,
  parameter int BANKS     = 8,
  parameter int SETS      = 128,
  parameter int WAYS      = 16,
  parameter int CNT_W     = 6,
  parameter int IVL_W     = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc_valid,
  output logic                    acc_ready,
  input  logic                    acc_fast,
  input  logic [ADDR_W-1:0]       acc_addr,
  output logic                    acc_rb_hit,
  output logic                    mig_valid,
  input  logic                    mig_ready,
  output logic [ADDR_W-ROW_SHIFT-1:0] mig_row,
  input  logic [CNT_W-1:0]        cfg_threshold,
  input  logic [IVL_W-1:0]        cfg_interval
);
  localparam int ROW_W  = ADDR_W - ROW_SHIFT;
  localparam int BANK_W = $clog2(BANKS);
  localparam int SET_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int TAG_W  = ROW_W - SET_W;

  logic [ROW_W-1:0] open_row [BANKS];
  logic [BANKS-1:0] open_vld;
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [CNT_W-1:0] cnt_q [SETS][WAYS];
  logic [WAY_W-1:0] age_q [SETS][WAYS];
  logic [WAYS-1:0]  vld_q [SETS];
  logic [IVL_W-1:0] ivl_cnt;

  logic unused_lo;
  assign unused_lo = ^acc_addr[ROW_SHIFT-1:0];

  wire [ROW_W-1:0]  row  = acc_addr[ADDR_W-1:ROW_SHIFT];
  wire [BANK_W-1:0] bank = row[BANK_W-1:0];
  wire [SET_W-1:0]  set  = row[SET_W-1:0];
  wire [TAG_W-1:0]  tag  = row[ROW_W-1:SET_W];

  assign acc_rb_hit = open_vld[bank] && (open_row[bank] == row);
  assign acc_ready  = !mig_valid || mig_ready;

  wire take    = acc_valid && acc_ready && !acc_fast;
  wire rb_miss = !acc_rb_hit;
  wire tick    = (cfg_interval != '0) && (ivl_cnt >= cfg_interval - 1'b1);

  logic             hit_any, free_any, tbl_hit, fire;
  logic [WAY_W-1:0] hit_way, free_way, lru_way, use_way, touch_age;
  logic [CNT_W-1:0] old_cnt, new_cnt;

  always_comb begin
    hit_any  = 1'b0;
    free_any = 1'b0;
    hit_way  = '0;
    free_way = '0;
    lru_way  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (vld_q[set][w] && tag_q[set][w] == tag) begin
        hit_any = 1'b1;
        hit_way = WAY_W'(w);
      end
      if (!vld_q[set][w]) begin
        free_any = 1'b1;
        free_way = WAY_W'(w);
      end
      if (age_q[set][w] == WAY_W'(WAYS - 1)) lru_way = WAY_W'(w);
    end
    tbl_hit   = hit_any && !tick;
    use_way   = tbl_hit ? hit_way : tick ? '0 : free_any ? free_way : lru_way;
    touch_age = age_q[set][use_way];
    old_cnt   = tbl_hit ? cnt_q[set][hit_way] : '0;
    new_cnt   = (rb_miss && old_cnt != '1) ? old_cnt + 1'b1 : old_cnt;
    fire      = rb_miss && (cfg_threshold != '0) && (new_cnt >= cfg_threshold);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mig_valid <= 1'b0;
      mig_row   <= '0;
      ivl_cnt   <= '0;
      open_vld  <= '0;
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
      end
    end else begin
      ivl_cnt <= tick ? '0 : ivl_cnt + 1'b1;
      if (mig_valid && mig_ready) mig_valid <= 1'b0;
      if (tick)
        for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
      if (take) begin
        if (rb_miss) open_vld[bank] <= 1'b1;
        if (fire) begin
          mig_valid <= 1'b1;
          mig_row   <= row;
          if (tbl_hit) vld_q[set][hit_way] <= 1'b0;
        end else begin
          vld_q[set][use_way] <= 1'b1;
          for (int w = 0; w < WAYS; w++)
            if (WAY_W'(w) == use_way) age_q[set][w] <= '0;
            else if (age_q[set][w] < touch_age) age_q[set][w] <= age_q[set][w] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take && rb_miss) open_row[bank] <= row;
    if (take && !fire) begin
      tag_q[set][use_way] <= tag;
      cnt_q[set][use_way] <= new_cnt;
    end
  end
endmodule

// File: rtl/rowmiss_promoter_sva.sv
module rowmiss_promoter_sva #(
  parameter int ADDR_W    = 40,
  parameter int ROW_SHIFT = 12,
  parameter int CNT_W     = 6
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        acc_valid,
  input logic                        acc_ready,
  input logic                        acc_fast,
  input logic [ADDR_W-1:0]           acc_addr,
  input logic                        acc_rb_hit,
  input logic                        mig_valid,
  input logic                        mig_ready,
  input logic [ADDR_W-ROW_SHIFT-1:0] mig_row,
  input logic [CNT_W-1:0]            cfg_threshold
);
  logic unused_lo;
  assign unused_lo = ^acc_addr[ROW_SHIFT-1:0];
  wire [ADDR_W-ROW_SHIFT-1:0] row = acc_addr[ADDR_W-1:ROW_SHIFT];
  wire room = !mig_valid || mig_ready;

  AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mig_valid && !mig_ready) |=> (mig_valid && $stable(mig_row))); // R7
  AST_STALL_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (mig_valid && !mig_ready) |-> !acc_ready); // R7
  AST_ZERO_THR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_threshold == '0 && room) |=> !mig_valid); // R5
  AST_FAST_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_fast && room) |=> !mig_valid); // R1
  AST_HIT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_fast && acc_rb_hit && room) |=> !mig_valid); // R5
  AST_SAME_ROW_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_fast && $past(acc_valid && acc_ready && !acc_fast)
     && row == $past(row)) |-> acc_rb_hit); // R2
endmodule

bind rowmiss_promoter rowmiss_promoter_sva #(
  .ADDR_W(ADDR_W), .ROW_SHIFT(ROW_SHIFT), .CNT_W(CNT_W)
) u_sva (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
  .acc_fast(acc_fast), .acc_addr(acc_addr), .acc_rb_hit(acc_rb_hit),
  .mig_valid(mig_valid), .mig_ready(mig_ready), .mig_row(mig_row),
  .cfg_threshold(cfg_threshold)
);

// File: tb/rowmiss_promoter_test.sv
module rowmiss_promoter_test;
  localparam int AW = 16, SH = 8, NB = 2, NS = 4, NW = 2, CW = 3, IW = 8;
  localparam int CMAX = 7;

  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, acc_fast = 0, mig_ready = 0;
  logic [AW-1:0] acc_addr = '0;
  logic [CW-1:0] cfg_threshold = '0;
  logic [IW-1:0] cfg_interval = '0;
  logic acc_ready, acc_rb_hit, mig_valid;
  logic [AW-SH-1:0] mig_row;

  always #5 clk = ~clk;

  rowmiss_promoter #(.ADDR_W(AW), .ROW_SHIFT(SH), .BANKS(NB), .SETS(NS),
    .WAYS(NW), .CNT_W(CW), .IVL_W(IW)) uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_fast(acc_fast), .acc_addr(acc_addr), .acc_rb_hit(acc_rb_hit),
    .mig_valid(mig_valid), .mig_ready(mig_ready), .mig_row(mig_row),
    .cfg_threshold(cfg_threshold), .cfg_interval(cfg_interval));

  int checks = 0, errors = 0;
  bit done = 0;
  string cur = "R10";

  int m_or[NB]; bit m_ov[NB];
  bit m_v[NS][NW]; int m_t[NS][NW]; int m_c[NS][NW]; int m_a[NS][NW];
  bit m_migv = 0; int m_migrow = 0; int m_ivl = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", cur, what, act, exp);
    end
  endtask

  function automatic logic [15:0] nxt(input logic [15:0] x);
    return {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
  endfunction

  task automatic step(input bit v, input bit f, input int rowv, input bit rdy);
    int bank, set, tag, hw, uw, oc, nc, ta;
    bit exp_ready, exp_hit, take, tick, fire, found;
    @(negedge clk);
    acc_valid = v; acc_fast = f; mig_ready = rdy;
    acc_addr = {rowv[7:0], lfsr[7:0]};
    #1;
    bank = rowv % NB; set = rowv % NS; tag = rowv / NS;
    exp_ready = !m_migv || rdy;
    chk(acc_ready == exp_ready, "R7 acc_ready", acc_ready, exp_ready);
    exp_hit = m_ov[bank] && m_or[bank] == rowv;
    if (v && !f) chk(acc_rb_hit == exp_hit, "R2 rb_hit", acc_rb_hit, exp_hit);
    take = v && exp_ready && !f;
    tick = cfg_interval != 0 && m_ivl >= int'(cfg_interval) - 1;
    if (m_migv && rdy) m_migv = 0;
    hw = -1;
    if (take && !tick)
      for (int w = 0; w < NW; w++) if (m_v[set][w] && m_t[set][w] == tag) hw = w;
    if (tick) foreach (m_v[s, w]) m_v[s][w] = 0;
    if (take) begin
      if (!exp_hit) begin m_or[bank] = rowv; m_ov[bank] = 1; end
      uw = hw; found = hw >= 0;
      for (int w = NW - 1; w >= 0; w--) if (!found && !m_v[set][w]) uw = w;
      for (int w = 0; w < NW; w++) if (uw < 0 && m_a[set][w] == NW - 1) uw = w;
      oc = (hw >= 0) ? m_c[set][hw] : 0;
      nc = (!exp_hit && oc < CMAX) ? oc + 1 : oc;
      fire = !exp_hit && cfg_threshold != 0 && nc >= int'(cfg_threshold);
      if (fire) begin
        m_migv = 1; m_migrow = rowv;
        if (hw >= 0) m_v[set][hw] = 0;
      end else begin
        ta = m_a[set][uw];
        m_v[set][uw] = 1; m_t[set][uw] = tag; m_c[set][uw] = nc;
        for (int w = 0; w < NW; w++)
          if (w == uw) m_a[set][w] = 0;
          else if (m_a[set][w] < ta) m_a[set][w]++;
      end
    end
    m_ivl = tick ? 0 : (m_ivl + 1) % 256;
    @(posedge clk); #1;
    chk(mig_valid == m_migv, "R5 mig_valid", mig_valid, m_migv);
    if (m_migv) chk(int'(mig_row) == m_migrow, "R5 mig_row", mig_row, m_migrow);
    lfsr = nxt(lfsr);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #3_000_000;
    checks++; errors++;
    $display("FAIL watchdog: got 0 expected 1 (run completion)");
    finish_run();
  end

  initial begin
    foreach (m_a[s, w]) begin m_a[s][w] = w; m_v[s][w] = 0; end
    foreach (m_ov[b]) m_ov[b] = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(mig_valid == 0, "R10 mig_valid reset", mig_valid, 0);
    chk(acc_ready == 1, "R10 acc_ready reset", acc_ready, 1);
    @(negedge clk); rst_n = 1;

    // R2: open-row tracking with migration disabled (R5 threshold 0)
    cur = "R2 R5";
    step(1, 0, 8'h10, 1); step(1, 0, 8'h10, 1); step(1, 0, 8'h12, 1);
    step(1, 0, 8'h10, 1); step(1, 0, 8'h11, 1); step(1, 0, 8'h10, 1);

    // R1: fast accesses leave the open row and counts alone
    cur = "R1";
    cfg_threshold = 2;
    step(1, 1, 8'h14, 1); step(1, 0, 8'h10, 1);
    step(1, 0, 8'h20, 1); step(1, 1, 8'h22, 1); step(1, 1, 8'h20, 1);
    step(1, 0, 8'h22, 1); step(1, 0, 8'h20, 1); step(0, 0, 0, 1);

    // R3 R6: hits do not count; request clears entry
    cur = "R3 R6";
    step(1, 0, 8'h30, 1); step(1, 0, 8'h30, 1); step(1, 0, 8'h30, 1);
    step(1, 0, 8'h32, 1); step(1, 0, 8'h30, 1); step(1, 0, 8'h32, 1);
    step(1, 0, 8'h30, 1); step(1, 0, 8'h32, 1); step(1, 0, 8'h30, 1);

    // R7: stalled request blocks input
    cur = "R7";
    cfg_threshold = 1;
    step(1, 0, 8'h40, 0); step(1, 0, 8'h42, 0); step(1, 0, 8'h44, 0);
    step(1, 0, 8'h42, 1); step(0, 0, 0, 1);

    // R4: LRU replacement in one set (two ways, three tags)
    cur = "R4";
    cfg_threshold = 3;
    step(1, 0, 8'h04, 1); step(1, 0, 8'h08, 1); step(1, 0, 8'h04, 1);
    step(1, 0, 8'h0C, 1); step(1, 0, 8'h04, 1); step(1, 0, 8'h08, 1);
    step(1, 0, 8'h04, 1); step(1, 0, 8'h0C, 1); step(0, 0, 0, 1);

    // R9: saturation visible by raising the threshold to the maximum
    cur = "R9";
    cfg_threshold = 0;
    for (int i = 0; i < 10; i++) begin step(1, 0, 8'h05, 1); step(1, 0, 8'h03, 1); end
    cfg_threshold = 7;
    step(1, 0, 8'h05, 1); step(0, 0, 0, 1);

    // R8: access in the clearing cycle counts as fresh
    cur = "R8";
    cfg_threshold = 2; cfg_interval = 6;
    step(1, 0, 8'h51, 1); step(1, 0, 8'h53, 1);
    while (m_ivl != int'(cfg_interval) - 1) step(0, 0, 0, 1);
    step(1, 0, 8'h51, 1); step(1, 0, 8'h53, 1); step(1, 0, 8'h51, 1);
    step(0, 0, 0, 1);

    // Mixed sweep over thresholds and intervals
    cur = "R3 R4 R5 R6 R7 R8";
    for (int t = 1; t <= 4; t++)
      for (int k = 0; k < 3; k++) begin
        cfg_threshold = CW'(t);
        cfg_interval = (k == 0) ? 8'd0 : (k == 1) ? 8'd23 : 8'd7;
        for (int i = 0; i < 300; i++)
          step(lfsr[9:8] != 0, lfsr[12:10] == 0, {4'h0, lfsr[3:0]}, lfsr[13]);
      end

    finish_run();
  end
endmodule